// File: doc/BRIEF.md
# Subsystem Soft-Reset and Processor-Halt Controller

This block sits between a host register port and a device subsystem. It gives the host two control bits. The first is a level-held soft reset. While that bit is set, the subsystem core is kept in reset and every core clock enable is turned off. The clock enable that feeds the host-facing logic stays on, so the host can keep reading and writing registers throughout.

The second bit halts the embedded processor. At hardware reset this bit takes the inverse of a boot-strap pin. A board that boots the processor from its own storage therefore lets it run at once. A board that downloads code from the host keeps the processor stopped until the host clears the bit.

Leaving soft reset follows a fixed order. The core clock enables come back first. The core reset is then held for a programmable number of cycles before it drops. A one-cycle configuration-load request is raised only when hardware reset is released, never when soft reset ends.

Top module: `srh_reset_ctl`

## Requirements
- R1: Writing 1 to bit 0 of word address 0 (soft-reset bit) asserts `core_rst` within two clock edges. The bit and `core_rst` stay set for as long as the host leaves the bit at 1; the bit never clears itself.
- R2: While the soft-reset bit is 1, every `clk_en` bit is 0 except bit `HOST_CLK_IDX` (default 0). That host bit is 1 at all times, including during hardware reset.
- R3: When the host writes 0 to the soft-reset bit at edge M, all `clk_en` bits are 1 after edge M+1. `core_rst` stays 1 until edge M+`HOLD_CYC` (default 4) and is 0 from then on.
- R4: Host register state is not disturbed by soft reset. The halt bit keeps its value, can be written during soft reset, and reads return correct data.
- R5: `cfg_load_req` is high for exactly one cycle, after the first clock edge at which hardware reset is low. It is never raised by entering or leaving soft reset.
- R6: While hardware reset is high, the halt bit (bit 0 of word address 1) and `cpu_halt` load the inverse of `boot_strap`.
- R7: After hardware reset is released, changes on `boot_strap` have no effect on `cpu_halt`.
- R8: Writing bit 0 of word address 1 sets `cpu_halt` to that value after the write edge. A value of 1 stops the processor and 0 lets it run.
- R9: A read returns the addressed bit in data bit 0, with all upper bits 0, and sets `host_rvalid` after the next edge. Reads of any address other than 0 or 1 return 0, and writes to such addresses change nothing.
- R10: During hardware reset, `core_rst` is 1, the soft-reset bit is 0, and only the host clock enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| host_wr_en | input | 1 | Register write strobe |
| host_rd_en | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Register word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| boot_strap | input | 1 | Boot-strap pin, sampled only during hardware reset |
| core_rst | output | 1 | Subsystem core reset, active high |
| clk_en | output | NUM_CLK | Per-domain clock enables |
| cpu_halt | output | 1 | Embedded processor halt, 1 = stopped |
| cfg_load_req | output | 1 | One-cycle configuration-load request after hardware reset |

## Verification
Hardware reset is applied once with the strap high and once with the strap low. This shows that the halt value comes from the pin's inverse and is not a fixed constant. After release, the strap is toggled to show that it no longer has any effect.

Soft reset is held for a long stretch. During that time the halt bit is rewritten and registers are read back, which separates the level-held reset from a pulse and confirms the host side stays live. The release is then sampled cycle by cycle to pin down the order: clocks return first, and the core reset drops `HOLD_CYC` edges later.

Writes of all-ones to an unmapped address and to the halt bit check that decoding is confined to bit 0 of the two mapped words.

// File: rtl/srh_pkg.sv
package srh_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SOFT = 2'd1,
    SEL_HALT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/srh_host_regs.sv
module srh_host_regs
  import srh_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int SOFT_ADDR = 0,
  parameter int HALT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              strap_in,
  output logic              soft_q,
  output logic              halt_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam logic [ADDR_W-1:0] SOFT_A = ADDR_W'(SOFT_ADDR);
  localparam logic [ADDR_W-1:0] HALT_A = ADDR_W'(HALT_ADDR);

  reg_sel_e sel;

  always_comb begin
    if (addr == SOFT_A)      sel = SEL_SOFT;
    else if (addr == HALT_A) sel = SEL_HALT;
    else                     sel = SEL_NONE;
  end

  // Register bits are cleared only by hardware reset; soft reset never reaches them.
  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
      halt_q <= ~strap_in;   // strap only matters while reset is held
    end else if (wr_en) begin
      case (sel)
        SEL_SOFT: soft_q <= wdata[0];
        SEL_HALT: halt_q <= wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        case (sel)
          SEL_SOFT: rdata <= DATA_W'(soft_q);
          SEL_HALT: rdata <= DATA_W'(halt_q);
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/srh_rst_seq.sv
module srh_rst_seq #(
  parameter int NUM_CLK      = 4,
  parameter int HOST_CLK_IDX = 0,
  parameter int HOLD_CYC     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_q,
  output logic               core_rst,
  output logic [NUM_CLK-1:0] clk_en
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // The counter reloads while soft reset is held and counts down once it is released.
  always_comb begin
    if (soft_q)            cnt_d = HOLD_V;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= HOLD_V;
      core_rst <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      core_rst <= (cnt_d != '0);
    end
  end

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_en
    if (i == HOST_CLK_IDX) begin : g_host
      always_ff @(posedge clk) clk_en[i] <= 1'b1;
    end else begin : g_core
      always_ff @(posedge clk) begin
        if (rst) clk_en[i] <= 1'b0;
        else     clk_en[i] <= ~soft_q;
      end
    end
  end
endmodule

// File: rtl/srh_cfg_load.sv
module srh_cfg_load (
  input  logic clk,
  input  logic rst,
  output logic load_req
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b1;
      load_req <= 1'b0;
    end else begin
      load_req <= pend_q;
      pend_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/srh_reset_ctl.sv
module srh_reset_ctl #(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32,
  parameter int NUM_CLK      = 4,
  parameter int HOST_CLK_IDX = 0,
  parameter int HOLD_CYC     = 4,
  parameter int SOFT_ADDR    = 0,
  parameter int HALT_ADDR    = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  input  logic               boot_strap,
  output logic               core_rst,
  output logic [NUM_CLK-1:0] clk_en,
  output logic               cpu_halt,
  output logic               cfg_load_req
);
  logic soft_bit;
  logic halt_bit;

  srh_host_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SOFT_ADDR(SOFT_ADDR), .HALT_ADDR(HALT_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(host_wr_en), .rd_en(host_rd_en),
    .addr(host_addr), .wdata(host_wdata),
    .strap_in(boot_strap),
    .soft_q(soft_bit), .halt_q(halt_bit),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );

  srh_rst_seq #(
    .NUM_CLK(NUM_CLK), .HOST_CLK_IDX(HOST_CLK_IDX), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .soft_q(soft_bit),
    .core_rst(core_rst), .clk_en(clk_en)
  );

  srh_cfg_load u_load (
    .clk(clk), .rst(rst), .load_req(cfg_load_req)
  );

  assign cpu_halt = halt_bit;
endmodule

// File: rtl/srh_ctl_checker.sv
module srh_ctl_checker #(
  parameter int ADDR_W       = 4,
  parameter int NUM_CLK      = 4,
  parameter int HOST_CLK_IDX = 0,
  parameter int HALT_ADDR    = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               soft_q,
  input logic               core_rst,
  input logic [NUM_CLK-1:0] clk_en,
  input logic               cpu_halt,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic               cfg_load_req
);
  localparam logic [NUM_CLK-1:0] HOST_MASK = NUM_CLK'(1) << HOST_CLK_IDX;

  AST_SOFT_HOLDS_CORE: assert property (@(posedge clk) disable iff (rst)
    soft_q |=> core_rst); // R1
  AST_HOST_CLK_ON: assert property (@(posedge clk) disable iff (rst)
    clk_en[HOST_CLK_IDX]); // R2
  AST_CORE_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
    soft_q |=> ((clk_en & ~HOST_MASK) == '0)); // R2
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (!soft_q && (&clk_en))); // R3
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cfg_load_req |=> !cfg_load_req); // R5
  AST_LOAD_NOT_SOFT: assert property (@(posedge clk) disable iff (rst)
    soft_q |-> !cfg_load_req); // R5
  AST_HALT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(HALT_ADDR)) |=> $stable(cpu_halt)); // R7
endmodule

bind srh_reset_ctl srh_ctl_checker #(
  .ADDR_W(ADDR_W), .NUM_CLK(NUM_CLK),
  .HOST_CLK_IDX(HOST_CLK_IDX), .HALT_ADDR(HALT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .soft_q(soft_bit), .core_rst(core_rst),
  .clk_en(clk_en), .cpu_halt(cpu_halt), .wr_en(host_wr_en),
  .addr(host_addr), .cfg_load_req(cfg_load_req)
);

// File: tb/srh_reset_ctl_bench.sv
module srh_reset_ctl_bench;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NC = 4;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;
  logic strap = 1'b1;
  logic core_rst;
  logic [NC-1:0] clk_en;
  logic cpu_halt;
  logic load_req;

  int n_tests = 0;
  int n_fail  = 0;
  int load_cnt = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  srh_reset_ctl u_srh_reset_ctl (
    .clk(clk), .rst(rst), .host_wr_en(wr_en), .host_rd_en(rd_en),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .host_rvalid(rvalid), .boot_strap(strap), .core_rst(core_rst),
    .clk_en(clk_en), .cpu_halt(cpu_halt), .cfg_load_req(load_req)
  );

  always @(posedge clk) if (load_req) load_cnt++;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) check("R9 unexpected read", rdata, '0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic hw_reset(input logic s);
    rst = 1'b1; strap = s;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    hw_reset(1'b1);
    check("R10 core_rst in reset", core_rst, 1);
    check("R10 clk_en in reset", clk_en, 4'b0001);
    check("R6 halt = ~strap(1)", cpu_halt, 0);
    check("R5 no load in reset", load_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R5 load pulse", load_req, 1);
    @(negedge clk);
    check("R5 load pulse ends", load_req, 0);
    repeat (HOLD) @(negedge clk);
    check("R10 core_rst released", core_rst, 0);
    check("R3 clocks on after reset", clk_en, 4'b1111);
    rd(0, 0, "R9 soft bit reads 0");
    rd(1, 0, "R9 halt bit reads 0");

    wr(1, 32'hFFFF_FFFF);
    check("R8 halt set", cpu_halt, 1);
    rd(1, 1, "R9 halt read upper bits zero");
    strap = 1'b0; repeat (3) @(negedge clk);
    strap = 1'b1; repeat (3) @(negedge clk);
    check("R7 strap ignored", cpu_halt, 1);

    load_cnt = 0;
    wr(0, 1);
    @(negedge clk);
    check("R1 core_rst asserted", core_rst, 1);
    check("R2 only host clock on", clk_en, 4'b0001);
    repeat (50) @(negedge clk);
    check("R1 still held", core_rst, 1);
    rd(0, 1, "R1 soft bit not self-clearing");
    rd(1, 1, "R4 halt kept in soft reset");
    wr(1, 0);
    check("R4 halt writable in soft reset", cpu_halt, 0);
    rd(1, 0, "R4 halt read in soft reset");
    check("R2 clocks still off", clk_en, 4'b0001);

    wr(0, 0);
    check("R3 clocks off before M+1", clk_en, 4'b0001);
    for (int j = 1; j < HOLD; j++) begin
      @(negedge clk);
      check("R3 clocks on", clk_en, 4'b1111);
      check("R3 core_rst held", core_rst, 1);
    end
    @(negedge clk);
    check("R3 core_rst drops at M+HOLD", core_rst, 0);
    repeat (3) @(negedge clk);
    check("R5 no load on soft reset", load_cnt, 0);

    wr(5, 32'hFFFF_FFFF);
    check("R9 unmapped write no reset", core_rst, 0);
    check("R9 unmapped write no halt", cpu_halt, 0);
    rd(5, 0, "R9 unmapped read zero");
    rd(0, 0, "R9 soft bit unchanged");

    hw_reset(1'b0);
    check("R6 halt = ~strap(0)", cpu_halt, 1);
    check("R10 soft bit cleared", clk_en, 4'b0001);
    rst = 1'b0;
    repeat (HOLD + 2) @(negedge clk);
    check("R6 halt held after release", cpu_halt, 1);
    rd(0, 0, "R10 soft bit zero after reset");

    repeat (3) @(negedge clk);
    check("R9 all reads returned", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule